// File: doc/BRIEF.md
# Configurable Serializer with Forwarded Clock

This block turns parallel words into a serial bit stream, one bit per cycle of the serial-rate clock. The number of bits per word (the serialization factor) is chosen from 3 to 10. An internal counter derived from that factor produces a one-cycle load pulse. Each pulse moves the word held in a load register into a shift register, which then sends it out most significant bit first.

A second lane, built from the same shift-register logic and driven by the same load pulse, sends a fixed bit pattern. That pattern forms a source-synchronous clock that travels next to the data. The pattern is set by a divisor code and a phase-inversion bit. Factor, divisor and phase are captured only while reset is asserted.

Words are offered with a strobe and land in the load register. When no word arrives during a frame, the last word is sent again.

Top module: `ser_tx`

## Requirements
- R1: The factor, divisor code and inversion bit are captured only on clock edges where `rst` is high. A factor below 3 is used as 3, and a factor above 10 is used as 10. Changing these inputs while `rst` is low has no effect until the next reset.
- R2: After reset is released, counting the first cycle with `rst` low as cycle 1, `load_en` is high for exactly one cycle, in cycle F. It then pulses once every F cycles, where F is the captured factor.
- R3: Both `ser_out` and `fwd_clk` are low in reset and stay low until the first `load_en` pulse has been taken. A strobe sampled before that point, including in the cycle of the first pulse, is ignored, so the first two frames carry zeros.
- R4: A word strobed during a frame is sent in the next frame. Bit F-1 is sent first, in the cycle after the load pulse, and the following bits come in descending order. Bits F and above are ignored.
- R5: If no strobe arrives during a frame, the word already in the load register is sent again.
- R6: For divisor code d in {1,2,4,6,8,10} where 2·d divides F, the forwarded clock sends d ones and then d zeros, repeated, starting at the first bit of every frame.
- R7: For every other divisor code, the forwarded clock sends ceil(F/2) ones followed by zeros in each frame, which is one clock period per word.
- R8: With the inversion bit set, every bit of the forwarded clock pattern in R6 or R7 is inverted, which gives a 180-degree phase shift.
- R9: The forwarded clock lane uses the same load pulse as the data lane. Its first pattern bit appears in the same cycle as the data's first bit, in every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst | input | 1 | Synchronous active-high reset; settings are captured while it is high |
| cfg_factor | input | 4 | Serialization factor request (clamped to 3..10) |
| cfg_fwd_div | input | 4 | Forwarded clock divisor code |
| cfg_fwd_inv | input | 1 | 1 selects a 180-degree forwarded clock phase |
| par_data | input | 10 | Parallel word; only the low F bits are used |
| par_valid | input | 1 | Word strobe |
| ser_out | output | 1 | Serial data, MSB first |
| fwd_clk | output | 1 | Forwarded clock lane output |
| load_en | output | 1 | One-cycle load pulse, once per frame |

## Verification
The hardest case to reach from the ports is a strobe that lands in the reset-release window or in the very cycle of the first load pulse. Such a strobe must be dropped. It is only visible as the absence of data two frames later. The bench holds the strobe high with an all-ones word from before reset is released through the first pulse. It then checks that the first two frames are all zero. Each configuration vector also changes the settings after reset is released and then checks that the frame length and the patterns do not change.

// File: rtl/ser_pkg.sv
package ser_pkg;
    localparam int MAX_W   = 10;
    localparam int MIN_F   = 3;
    localparam int FW      = $clog2(MAX_W + 1);
    localparam int N_LANES = 2;
    localparam int LANE_DATA = 0;
    localparam int LANE_FWD  = 1;

    typedef enum logic {PH_0 = 1'b0, PH_180 = 1'b1} phase_e;

    typedef struct packed {
        logic [FW-1:0] factor;
        logic [FW-1:0] div;
        phase_e        phase;
    } cfg_t;

    function automatic logic [FW-1:0] clamp_factor(input logic [FW-1:0] f);
        if (f < FW'(MIN_F))      return FW'(MIN_F);
        else if (f > FW'(MAX_W)) return FW'(MAX_W);
        else                     return f;
    endfunction

    // Forwarded clock word, MSB-aligned (first transmitted bit at MSB).
    function automatic logic [MAX_W-1:0] fwd_pattern(input logic [FW-1:0] f,
                                                     input logic [FW-1:0] d,
                                                     input phase_e      ph);
        logic [MAX_W-1:0] p;
        int fi, di;
        logic legal, b;
        fi    = int'(f);
        di    = (d == '0) ? 1 : int'(d);
        legal = (d == FW'(1) || d == FW'(2) || d == FW'(4) ||
                 d == FW'(6) || d == FW'(8) || d == FW'(10)) &&
                ((fi % (2 * di)) == 0);
        p = '0;
        for (int i = 0; i < MAX_W; i++) begin
            b = 1'b0;
            if (i < fi) begin
                b = legal ? (((i / di) % 2) == 0) : (i < ((fi + 1) / 2));
                b = b ^ (ph == PH_180);
            end
            p = {p[MAX_W-2:0], b};
        end
        return p;
    endfunction
endpackage

// File: rtl/ser_loadgen.sv
module ser_loadgen #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] factor,
    output logic          load_en,
    output logic          started
);
    logic [FW-1:0] cnt;
    logic          wrap;

    assign wrap    = (cnt == factor - FW'(1));
    assign load_en = !rst && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            started <= 1'b0;
        end else if (wrap) begin
            cnt     <= '0;
            started <= 1'b1;
        end else begin
            cnt <= cnt + FW'(1);
        end
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt < factor);
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !load_en);
endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] word,
    output logic         bit_out
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)          sh <= '0;
        else if (load_en) sh <= word;
        else              sh <= {sh[W-2:0], 1'b0};
    end

    assign bit_out = sh[W-1];

    p_msb_first_r4: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (bit_out == $past(word[W-1])));
endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [FW-1:0]        cfg_factor,
    input  logic [FW-1:0]        cfg_fwd_div,
    input  logic                 cfg_fwd_inv,
    input  logic [MAX_W-1:0]     par_data,
    input  logic                 par_valid,
    output logic                 ser_out,
    output logic                 fwd_clk,
    output logic                 load_en
);
    cfg_t             cfg_q;
    logic [MAX_W-1:0] pattern_q;
    logic [MAX_W-1:0] hold_q;
    logic [MAX_W-1:0] word_mask;
    logic             started;
    logic [FW-1:0]    fac_in;
    logic [MAX_W-1:0] lane_word [N_LANES];
    logic [N_LANES-1:0] lane_bit;

    assign fac_in = clamp_factor(cfg_factor);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '{factor: fac_in, div: cfg_fwd_div, phase: phase_e'(cfg_fwd_inv)};
            pattern_q <= fwd_pattern(fac_in, cfg_fwd_div, phase_e'(cfg_fwd_inv));
        end
    end

    ser_loadgen #(.FW(FW)) u_loadgen (
        .clk     (clk),
        .rst     (rst),
        .factor  (cfg_q.factor),
        .load_en (load_en),
        .started (started)
    );

    assign word_mask = ~({MAX_W{1'b1}} << cfg_q.factor);

    always_ff @(posedge clk) begin
        if (rst)                       hold_q <= '0;
        else if (par_valid && started) hold_q <= par_data & word_mask;
    end

    assign lane_word[LANE_DATA] = hold_q << (FW'(MAX_W) - cfg_q.factor);
    assign lane_word[LANE_FWD]  = pattern_q;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        ser_lane #(.W(MAX_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .load_en (load_en),
            .word    (lane_word[g]),
            .bit_out (lane_bit[g])
        );
    end

    assign ser_out = lane_bit[LANE_DATA];
    assign fwd_clk = lane_bit[LANE_FWD];

    p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg_q) && $stable(pattern_q));
    p_factor_range_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_q.factor >= FW'(MIN_F) && cfg_q.factor <= FW'(MAX_W));
    p_quiet_until_load_r3: assert property (@(posedge clk) disable iff (rst)
        !started |-> !ser_out && !fwd_clk);
    p_retain_word_r5: assert property (@(posedge clk) disable iff (rst)
        !par_valid |=> $stable(hold_q));
endmodule

// File: tb/tb_ser_tx.sv
module tb_ser_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cfg_factor = 4'd3;
    logic [3:0] cfg_fwd_div = 4'd1;
    logic       cfg_fwd_inv = 1'b0;
    logic [9:0] par_data = '0;
    logic       par_valid = 1'b0;
    logic       ser_out, fwd_clk, load_en;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ser_tx dut (
        .clk(clk), .rst(rst), .cfg_factor(cfg_factor), .cfg_fwd_div(cfg_fwd_div),
        .cfg_fwd_inv(cfg_fwd_inv), .par_data(par_data), .par_valid(par_valid),
        .ser_out(ser_out), .fwd_clk(fwd_clk), .load_en(load_en)
    );

    // {factor, divisor, invert, word}
    localparam logic [18:0] VEC [12] = '{
        {4'd3,  4'd1,  1'b0, 10'h3FD},
        {4'd4,  4'd1,  1'b0, 10'h009},
        {4'd4,  4'd2,  1'b1, 10'h006},
        {4'd8,  4'd4,  1'b0, 10'h0A5},
        {4'd8,  4'd2,  1'b0, 10'h03C},
        {4'd10, 4'd1,  1'b1, 10'h2B7},
        {4'd5,  4'd2,  1'b0, 10'h01F},
        {4'd7,  4'd6,  1'b1, 10'h055},
        {4'd2,  4'd1,  1'b0, 10'h006},
        {4'd15, 4'd10, 1'b0, 10'h2D1},
        {4'd6,  4'd1,  1'b0, 10'h02A},
        {4'd9,  4'd8,  1'b1, 10'h1A5}
    };

    task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int clampf(input int f);
        return (f < 3) ? 3 : ((f > 10) ? 10 : f);
    endfunction

    function automatic bit is_legal(input int f, input int d);
        return (d == 1 || d == 2 || d == 4 || d == 6 || d == 8 || d == 10) && ((f % (2 * d)) == 0);
    endfunction

    // Expected forwarded clock bits in arrival order, first bit at position f-1.
    function automatic logic [9:0] fwd_exp(input int f, input int d, input bit inv);
        logic [9:0] r = '0;
        bit b;
        for (int i = 0; i < f; i++) begin
            b = is_legal(f, d) ? (((i / d) % 2) == 0) : (i < ((f + 1) / 2));
            r = {r[8:0], b ^ inv};
        end
        return r;
    endfunction

    // Collect one frame starting at the negedge after a load pulse.
    task automatic get_frame(input int f, input bit strobe, input logic [9:0] w,
                             output logic [9:0] dat, output logic [9:0] ck, output bit le_ok);
        dat = '0; ck = '0; le_ok = 1'b1;
        for (int i = 0; i < f; i++) begin
            dat = {dat[8:0], ser_out};
            ck  = {ck[8:0], fwd_clk};
            if (load_en != (i == f - 1)) le_ok = 1'b0;
            if (strobe && i == 0) begin par_data = w; par_valid = 1'b1; end
            if (i == 1) par_valid = 1'b0;
            @(negedge clk);
        end
        par_valid = 1'b0;
    endtask

    task automatic start(input int f, input int d, input bit inv);
        par_valid = 1'b0;
        cfg_factor = 4'(f); cfg_fwd_div = 4'(d); cfg_fwd_inv = inv;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_vec(input int f, input int d, input bit inv, input logic [9:0] w);
        int fe;
        logic [9:0] dat, ck, m, ef;
        bit ok;
        fe = clampf(f);
        m  = w & ((10'd1 << fe) - 10'd1);
        ef = fwd_exp(fe, d, inv);
        start(f, d, inv);
        chk(!ser_out && !fwd_clk && !load_en, "R3 reset state", {7'd0, ser_out, fwd_clk, load_en}, '0);
        for (int k = 0; k < fe; k++) begin
            chk(load_en == (k == fe - 1), "R2 first load pulse (R1 clamp)", {9'd0, load_en}, {9'd0, k == fe - 1});
            chk(!ser_out, "R3 quiet before first load", {9'd0, ser_out}, '0);
            @(negedge clk);
        end
        get_frame(fe, 1'b1, w, dat, ck, ok);
        chk(dat == '0, "R3 first frame carries zeros", dat, '0);
        chk(ck == ef, is_legal(fe, d) ? "R6 fwd pattern" : "R7 fwd pattern", ck, ef);
        chk(ok, "R2 frame period", {9'd0, ok}, 10'd1);
        cfg_factor  = (fe == 10) ? 4'd3 : 4'd10;
        cfg_fwd_div = 4'd2;
        cfg_fwd_inv = ~inv;
        get_frame(fe, 1'b0, '0, dat, ck, ok);
        chk(dat == m, "R4 word MSB first, high bits ignored", dat, m);
        chk(ck == ef, inv ? "R8 inverted fwd pattern" : "R9 fwd aligned to data", ck, ef);
        chk(ok, "R1 settings frozen outside reset", {9'd0, ok}, 10'd1);
        get_frame(fe, 1'b0, '0, dat, ck, ok);
        chk(dat == m, "R5 word retransmitted", dat, m);
        chk(ck == ef, "R9 fwd repeats per frame", ck, ef);
    endtask

    initial begin
        logic [9:0] dat, ck;
        bit ok;
        for (int v = 0; v < 12; v++)
            run_vec(int'(VEC[v][18:15]), int'(VEC[v][14:11]), VEC[v][10], VEC[v][9:0]);

        // Strobe held through reset release and the first load cycle.
        par_data = 10'h3FF;
        cfg_factor = 4'd5; cfg_fwd_div = 4'd1; cfg_fwd_inv = 1'b0;
        rst = 1'b1;
        par_valid = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 5; k++) @(negedge clk);
        par_valid = 1'b0;
        chk(fwd_clk == 1'b1, "R9 fwd first bit with data MSB", {9'd0, fwd_clk}, 10'd1);
        get_frame(5, 1'b0, '0, dat, ck, ok);
        chk(dat == '0, "R3 early strobe ignored (frame 1)", dat, '0);
        get_frame(5, 1'b0, '0, dat, ck, ok);
        chk(dat == '0, "R3 early strobe ignored (frame 2)", dat, '0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule